// File: doc/BRIEF.md
# Chained Converter Readout Controller

This block is the host-side master for a string of 14-bit sampling converters wired as one long shift register on a three-wire serial port. On a start request it raises the convert line and then waits for the conversions to finish. It then clocks the whole chain out and delivers one parallel word per converter, together with a single-cycle valid strobe.

Two chain modes are supported, and the block picks one per transaction. In timed mode the serial clock rests low when convert rises, and readback begins after a fixed, parameterized number of cycles. In busy-flag mode the serial clock rests high when convert rises. Readback then begins on the rising edge of the busy line, which is the data output of the converter nearest the host. One extra clock pulse consumes the leading busy bit, and that bit is discarded. Chain length, word width, serial clock half-period and conversion wait are all parameters.

Top module: `chain_rdout_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `cnv_o`, `sck_o` and `valid_o` are low and `ready_o` is high.
- R2: At the cycle where `cnv_o` rises, `sck_o` equals the mode latched at start: 0 for timed mode (`busy_mode_i`=0), 1 for busy-flag mode (`busy_mode_i`=1).
- R3: `cnv_o` stays high from its rise until the cycle of the `valid_o` pulse, and is low in the cycle after it.
- R4: In timed mode the first `sck_o` rise comes exactly CONV_CYC clock cycles after `cnv_o` rises, and a readback has exactly 14×N_DEV falling `sck_o` edges.
- R5: In busy-flag mode readback starts only after a rising edge on `irq_i`, has exactly 14×N_DEV+1 falling `sck_o` edges, and the first captured bit (the busy flag) is not part of any word.
- R6: Each bit is captured from `sdi_i` in the clock cycle where `sck_o` is driven from high to low. Every low phase of `sck_o` during readback lasts exactly SCK_HALF cycles.
- R7: Word k of `words_o` (bits k×14+13 down to k×14) holds the word of the k-th converter counted from the host (k=0 is the nearest). Each word is received MSB first, and the nearest converter's word comes first in the stream.
- R8: `valid_o` is high for exactly one cycle per transaction.
- R9: `start_i` has no effect while `ready_o` is low. `ready_o` returns high in the cycle after the valid pulse.
- R10: `sck_o` is low whenever the controller is idle and after the last readback pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a convert-and-read transaction when idle |
| busy_mode_i | input | 1 | Mode for the next transaction: 1 busy-flag, 0 timed |
| irq_i | input | 1 | Busy line from the nearest converter's data output |
| sdi_i | input | 1 | Serial data from the chain |
| cnv_o | output | 1 | Convert line to all converters |
| sck_o | output | 1 | Serial clock to all converters |
| words_o | output | N_DEV×14 | Received words, word 0 from the nearest converter |
| valid_o | output | 1 | One-cycle strobe marking `words_o` complete |
| ready_o | output | 1 | High while idle and able to accept `start_i` |

## Verification
A three-converter chain is driven in both modes with all-zero and all-one data and with an alternating pattern. A single one is also walked through each of the 42 stream positions, and a set of pseudo-random words is used. The walking one exposes any slip in bit order, word order or word boundary, and the one-bit offset that the discarded busy bit would cause if it were kept. All-ones shows whether the busy bit leaks into a word. Busy delays shorter and longer than the timed wait show that busy-flag mode follows the busy edge and not the timer. Start pulses issued in mid-transaction with the opposite mode show that they are ignored.

// File: rtl/crc_pkg.sv
package crc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONV,
        ST_WAIT_BUSY,
        ST_HIGH,
        ST_LOW,
        ST_DONE
    } crc_state_e;
endpackage

// File: rtl/crc_down_timer.sv
module crc_down_timer #(
    parameter int TMR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] val_i,
    output logic             done_o
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/crc_rise_det.sv
module crc_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb prev_d = sig_i;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/crc_deser.sv
module crc_deser #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    shift_i,
    input  logic                    bit_i,
    output logic [N_DEV*WORD_W-1:0] words_o
);
    localparam int STREAM_W = N_DEV * WORD_W;

    logic [STREAM_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clear_i)
            sr_d = '0;
        else if (shift_i)
            sr_d = {sr_q[STREAM_W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    // earliest-received word (nearest converter) sits at the top of the register
    for (genvar k = 0; k < N_DEV; k++) begin : g_word
        assign words_o[k*WORD_W +: WORD_W] = sr_q[(N_DEV-1-k)*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/chain_rdout_ctrl.sv
module chain_rdout_ctrl
    import crc_pkg::*;
#(
    parameter int N_DEV    = 3,
    parameter int WORD_W   = 14,
    parameter int SCK_HALF = 2,
    parameter int CONV_CYC = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    busy_mode_i,
    input  logic                    irq_i,
    input  logic                    sdi_i,
    output logic                    cnv_o,
    output logic                    sck_o,
    output logic [N_DEV*WORD_W-1:0] words_o,
    output logic                    valid_o,
    output logic                    ready_o
);
    localparam int STREAM_W = N_DEV * WORD_W;
    localparam int CNT_W    = $clog2(STREAM_W + 2);
    localparam int TMR_MAX  = (CONV_CYC > SCK_HALF) ? CONV_CYC : SCK_HALF;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] CONV_LOAD = TMR_W'(CONV_CYC - 1);
    localparam logic [TMR_W-1:0] HALF_LOAD = TMR_W'(SCK_HALF - 1);

    typedef struct packed {
        crc_state_e       st;
        logic             mode;
        logic             cnv;
        logic             sck;
        logic             valid;
        logic [CNT_W-1:0] pulses;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, mode: 1'b0, cnv: 1'b0,
                                 sck: 1'b0, valid: 1'b0, pulses: '0};

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             busy_rise;
    logic             shift_en;
    logic             sr_clear;
    logic [CNT_W-1:0] last_pulse;
    logic             mode_q;

    crc_down_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    crc_rise_det u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (irq_i),
        .rise_o (busy_rise)
    );

    crc_deser #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sr_clear),
        .shift_i (shift_en),
        .bit_i   (sdi_i),
        .words_o (words_o)
    );

    // busy-flag mode has one extra leading pulse for the flag bit
    assign last_pulse = ctl_q.mode ? CNT_W'(STREAM_W) : CNT_W'(STREAM_W - 1);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        shift_en    = 1'b0;
        sr_clear    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.sck = 1'b0;
                ctl_d.cnv = 1'b0;
                if (start_i) begin
                    ctl_d.mode = busy_mode_i;
                    ctl_d.sck  = busy_mode_i;   // rest level picks the chain mode
                    ctl_d.st   = ST_SETUP;
                    sr_clear   = 1'b1;
                end
            end
            ST_SETUP: begin
                ctl_d.cnv    = 1'b1;
                ctl_d.pulses = '0;
                if (ctl_q.mode) begin
                    ctl_d.st = ST_WAIT_BUSY;
                end else begin
                    ctl_d.st = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = CONV_LOAD;
                end
            end
            ST_CONV: begin
                if (tmr_done) begin
                    ctl_d.sck = 1'b1;
                    ctl_d.st  = ST_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = HALF_LOAD;
                end
            end
            ST_WAIT_BUSY: begin
                if (busy_rise) begin
                    ctl_d.st = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LOAD;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    // capture just before the falling edge; drop the busy flag
                    shift_en  = !(ctl_q.mode && (ctl_q.pulses == '0));
                    ctl_d.sck = 1'b0;
                    ctl_d.st  = ST_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = HALF_LOAD;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    if (ctl_q.pulses == last_pulse) begin
                        ctl_d.st    = ST_DONE;
                        ctl_d.valid = 1'b1;
                    end else begin
                        ctl_d.pulses = ctl_q.pulses + 1'b1;
                        ctl_d.sck    = 1'b1;
                        ctl_d.st     = ST_HIGH;
                        tmr_load     = 1'b1;
                        tmr_val      = HALF_LOAD;
                    end
                end
            end
            ST_DONE: begin
                ctl_d.cnv = 1'b0;
                ctl_d.st  = ST_IDLE;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign cnv_o   = ctl_q.cnv;
    assign sck_o   = ctl_q.sck;
    assign valid_o = ctl_q.valid;
    assign ready_o = (ctl_q.st == ST_IDLE);
    assign mode_q  = ctl_q.mode;
endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 14
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_o,
    input logic sck_o,
    input logic valid_o,
    input logic ready_o,
    input logic mode_q
);
    localparam int STREAM_W = N_DEV * WORD_W;
    localparam int FC_W     = $clog2(STREAM_W + 3);

    logic            cnv_prev, sck_prev;
    logic [FC_W-1:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_prev <= 1'b0;
            sck_prev <= 1'b0;
            fall_cnt <= '0;
        end else begin
            cnv_prev <= cnv_o;
            sck_prev <= sck_o;
            if (cnv_o && !cnv_prev)
                fall_cnt <= '0;
            else if (sck_prev && !sck_o)
                fall_cnt <= fall_cnt + 1'b1;
        end
    end

    p_mode_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !cnv_prev) |-> (sck_o == mode_q));

    p_cnv_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !valid_o) |=> cnv_o);

    p_cnv_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !cnv_o);

    p_valid_cnv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cnv_o);

    p_fall_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !mode_q) |-> (fall_cnt == FC_W'(STREAM_W)));

    p_fall_count_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_q) |-> (fall_cnt == FC_W'(STREAM_W + 1)));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_ready_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> ready_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!sck_o && !cnv_o));
endmodule

bind chain_rdout_ctrl crc_checker #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnv_o   (cnv_o),
    .sck_o   (sck_o),
    .valid_o (valid_o),
    .ready_o (ready_o),
    .mode_q  (mode_q)
);

// File: tb/test_chain_rdout_ctrl.sv
module test_chain_rdout_ctrl;
    localparam int N        = 3;
    localparam int W        = 14;
    localparam int HALF     = 2;
    localparam int CONV     = 20;
    localparam int NW       = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          busy_mode_i = 1'b0;
    logic          sdi = 1'b0;
    logic          cnv_o, sck_o, valid_o, ready_o;
    logic [NW-1:0] words_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chain_rdout_ctrl #(.N_DEV(N), .WORD_W(W), .SCK_HALF(HALF), .CONV_CYC(CONV)) i_chain_rdout_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .busy_mode_i (busy_mode_i),
        .irq_i       (sdi),
        .sdi_i       (sdi),
        .cnv_o       (cnv_o),
        .sck_o       (sck_o),
        .words_o     (words_o),
        .valid_o     (valid_o),
        .ready_o     (ready_o)
    );

    // ---------------- chain model and monitors (all at negedge) ----------
    logic [W-1:0] dev_w [N];
    logic [NW:0]  chain = '0;
    logic         conv_done = 1'b0;
    int           conv_wait = 0;
    int           conv_delay = 5;
    logic         cnv_prev = 1'b0, sck_prev = 1'b0;
    int           cyc = 0;
    int           cnv_cyc = 0, rise_cyc = 0, fall_cyc = 0;
    logic         first_rise_seen = 1'b0;
    logic         mode_seen = 1'b0;
    int           fall_cnt = 0;
    logic         early = 1'b0, lowbad = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            chain = '0; conv_done = 1'b0;
        end else begin
            if (cnv_o && !cnv_prev) begin
                cnv_cyc = cyc; mode_seen = sck_o; conv_wait = 0;
                first_rise_seen = 1'b0;
            end
            if (!cnv_o && cnv_prev) conv_done = 1'b0;
            if (cnv_o && !conv_done) begin
                conv_wait++;
                if (conv_wait >= conv_delay) begin
                    logic [NW-1:0] s;
                    for (int k = 0; k < N; k++)
                        for (int b = 0; b < W; b++)
                            s[NW-1 - (k*W + (W-1-b))] = dev_w[k][b];
                    chain = mode_seen ? {1'b1, s} : {s, 1'b0};
                    conv_done = 1'b1;
                end
            end
            if (sck_prev && !sck_o) begin
                fall_cnt++;
                fall_cyc = cyc;
                if (!conv_done) early = 1'b1;
                chain = {chain[NW-1:0], 1'b0};
            end
            if (!sck_prev && sck_o && cnv_o) begin
                if (first_rise_seen) begin
                    if (cyc - fall_cyc != HALF) lowbad = 1'b1;
                end else begin
                    rise_cyc = cyc;
                    first_rise_seen = 1'b1;
                end
            end
        end
        cnv_prev = cnv_o;
        sck_prev = sck_o;
        sdi = conv_done ? chain[NW] : 1'b0;
    end

    // ---------------- helpers ---------------------------------------------
    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic m, input int bdelay, input logic poke);
        int t;
        fall_cnt = 0; early = 1'b0; lowbad = 1'b0;
        conv_delay = m ? bdelay : 5;
        @(negedge clk);
        busy_mode_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 0;
        while (!valid_o) begin
            @(negedge clk);
            if (poke && t == 12) begin start_i = 1'b1; busy_mode_i = ~m; end
            if (poke && t == 13) start_i = 1'b0;
            t++;
        end
        for (int k = 0; k < N; k++)
            check(words_o[k*W +: W] == dev_w[k], m ? "R5/R7 word" : "R7 word",
                  64'(words_o[k*W +: W]), 64'(dev_w[k]));
        check(mode_seen == m, "R2 sck level at cnv rise", 64'(mode_seen), 64'(m));
        check(cnv_o == 1'b1, "R3 cnv high at valid", 64'(cnv_o), 1);
        check(fall_cnt == (m ? NW + 1 : NW), m ? "R5 fall count" : "R4 fall count",
              64'(fall_cnt), 64'(m ? NW + 1 : NW));
        check(!early, "R5 readback before conversion end", 64'(early), 0);
        check(!lowbad, "R6 low phase length", 64'(lowbad), 0);
        if (!m)
            check(rise_cyc - cnv_cyc == CONV, "R4 conversion wait",
                  64'(rise_cyc - cnv_cyc), 64'(CONV));
        if (poke)
            check(busy_mode_i != m, "R9 start ignored while busy", 64'(busy_mode_i), 64'(~m));
        @(negedge clk);
        check(!valid_o, "R8 valid one cycle", 64'(valid_o), 0);
        check(!cnv_o, "R3 cnv drop after valid", 64'(cnv_o), 0);
        check(ready_o, "R9 ready after valid", 64'(ready_o), 1);
        check(!sck_o, "R10 sck low at end", 64'(sck_o), 0);
        check(fall_cnt == (m ? NW + 1 : NW), "R9 no extra transaction", 64'(fall_cnt),
              64'(m ? NW + 1 : NW));
        busy_mode_i = 1'b0;
    endtask

    task automatic both_modes(input int idx, input logic poke);
        int bd;
        bd = (idx % 3 == 0) ? 3 : ((idx % 3 == 1) ? 17 : 40);
        run_txn(1'b0, bd, poke);
        run_txn(1'b1, bd, poke);
    endtask

    // ---------------- watchdog --------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus --------------------------------------------
    initial begin
        int seed;
        for (int k = 0; k < N; k++) dev_w[k] = '0;
        repeat (4) @(negedge clk);
        check(!cnv_o && !sck_o && !valid_o && ready_o, "R1 reset state",
              {60'd0, cnv_o, sck_o, valid_o, ready_o}, 64'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cnv_o && !sck_o && !valid_o && ready_o, "R1 state after reset",
              {60'd0, cnv_o, sck_o, valid_o, ready_o}, 64'h1);

        // all zero, all one, alternating
        both_modes(0, 1'b0);
        for (int k = 0; k < N; k++) dev_w[k] = '1;
        both_modes(1, 1'b1);
        for (int k = 0; k < N; k++) dev_w[k] = (k % 2 == 0) ? 14'h2AAA : 14'h1555;
        both_modes(2, 1'b0);

        // walking one through every stream position
        for (int p = 0; p < NW; p++) begin
            for (int k = 0; k < N; k++) dev_w[k] = '0;
            dev_w[p / W][W - 1 - (p % W)] = 1'b1;
            both_modes(p, (p % 11) == 5);
        end

        // pseudo-random words
        seed = 32'h1234_5678;
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < N; k++) begin
                seed = seed * 1103515245 + 12345;
                dev_w[k] = seed[29:16];
            end
            both_modes(r, r == 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule